// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Matcher

This block listens on the clock and data lines of a two-wire (I2C) bus and decides whether the address byte that follows a START or repeated START selects this device. It cleans both lines with a synchronizer and a glitch filter running on the system clock. It then finds START and STOP conditions, shifts in the eight address-phase bits and compares the seven address bits with a primary address register. A second register, chosen by one control bit, works either as a per-bit don't-care mask over the primary address or as a second complete address. General call recognition can be turned on. A promiscuous mode accepts every address, so software can decode any set of addresses it likes.

When the address is accepted, the block pulls the data line low for the acknowledge clock pulse. It also raises registered flags: match, the R/W bit, general call and a 10-bit header marker, plus a one-cycle pulse at the moment of the match. Anything after the address phase is left to other logic. If the address is not accepted, the block stays off the bus until the next START or STOP.

Top module: `i2c_addr_match`

## Requirements
- R1: A level on either bus line that lasts less than 2 system clocks does not change the filtered level. A level that lasts 2 clocks or more is accepted.
- R2: A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. A STOP clears every flag and returns the block to idle. A repeated START clears the flags and restarts address reception.
- R3: The address byte is taken MSB first. Bits 7..1 are the address and bit 0 is R/W. On an accepted address, `sda_pull` is 1 during the 9th clock pulse and returns to 0 after that pulse's falling edge. `match` is then 1.
- R4: On an address that is not accepted, the data line is never pulled and no flag is raised. Further bytes are ignored until the next START or STOP.
- R5: With `gc_en` = 1, address 0000000 with R/W = 0 is accepted and `gcall` = 1. Address 0000000 with R/W = 1 is not accepted. With `gc_en` = 0, address 0000000 is not accepted.
- R6: With `alt_mask` = 1, each 1 bit in `alt_addr` makes the corresponding address bit a don't-care in the comparison with `own_addr`.
- R7: With `alt_mask` = 0, an address equal to either `own_addr` or `alt_addr` is accepted.
- R8: With `promisc` = 1, every address is accepted.
- R9: `ten_hdr` is 1 together with `match` when the accepted address has the form 11110xx. For any other accepted address it is 0.
- R10: `rw` holds the R/W bit of the accepted byte. `match`, `rw`, `gcall` and `ten_hdr` hold their values until the next START or STOP.
- R11: `match_pulse` is high for exactly one clock for each accepted address.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| own_addr | input | 7 | Primary slave address |
| alt_addr | input | 7 | Mask or second address |
| alt_mask | input | 1 | 1: alt_addr is a don't-care mask; 0: second address |
| gc_en | input | 1 | Accept the general call address |
| promisc | input | 1 | Accept every address |
| sda_pull | output | 1 | 1 drives the data line low (acknowledge) |
| match | output | 1 | Address accepted in the current transfer |
| rw | output | 1 | R/W bit of the accepted byte |
| gcall | output | 1 | Accepted through general call |
| ten_hdr | output | 1 | Accepted byte is a 10-bit header (11110xx) |
| match_pulse | output | 1 | One-clock pulse when an address is accepted |

## Verification
A corrupted bit counter or shift register shows up first at the acknowledge slot. The data line is then pulled during the wrong clock pulse, or the wrong address is acknowledged, and both can be seen within one byte time on the bus. A state machine stuck in the acknowledge state leaves the data line pulled after the 9th falling edge. A stuck filter or edge detector keeps flags from clearing after a STOP, or lets a one-clock glitch act as a START. The bench samples the line and the flags a few clocks after each bus edge to catch these cases.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int FILT_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [6:0] own_addr,
  input  logic [6:0] alt_addr,
  input  logic       alt_mask,
  input  logic       gc_en,
  input  logic       promisc,
  output logic       sda_pull,
  output logic       match,
  output logic       rw,
  output logic       gcall,
  output logic       ten_hdr,
  output logic       match_pulse
);
  localparam int CW = $clog2(FILT_LEN + 1);

  typedef enum logic [1:0] {IDLE, ADDR, ACK, SKIP} st_t;

  logic [1:0] raw, s1, s2, filt, prev;
  assign raw = {scl_in, sda_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 2'b11;
      s2 <= 2'b11;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  for (genvar i = 0; i < 2; i++) begin : g_filt
    logic          lvl;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        lvl <= 1'b1;
        cnt <= '0;
      end else if (s2[i] == lvl) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        lvl <= s2[i];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    assign filt[i] = lvl;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 2'b11;
    else        prev <= filt;

  logic scl, sda, start, stop, rise, fall;
  assign scl   = filt[1];
  assign sda   = filt[0];
  assign start = scl & prev[1] & prev[0] & ~sda;
  assign stop  = scl & prev[1] & ~prev[0] & sda;
  assign rise  = scl & ~prev[1];
  assign fall  = ~scl & prev[1];

  st_t        st;
  logic [3:0] nbits;
  logic [7:0] sh;
  logic [6:0] addr, diff;
  logic       prim, sec, gc_hit, take;

  assign addr   = sh[7:1];
  assign diff   = addr ^ own_addr;
  assign prim   = alt_mask ? ((diff & ~alt_addr) == 7'd0) : (diff == 7'd0);
  assign sec    = ~alt_mask & (addr == alt_addr);
  assign gc_hit = gc_en & (addr == 7'd0) & ~sh[0];
  assign take   = promisc | prim | sec | gc_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st          <= IDLE;
      nbits       <= '0;
      sh          <= '0;
      sda_pull    <= 1'b0;
      match       <= 1'b0;
      rw          <= 1'b0;
      gcall       <= 1'b0;
      ten_hdr     <= 1'b0;
      match_pulse <= 1'b0;
    end else begin
      match_pulse <= 1'b0;
      if (start || stop) begin
        st       <= start ? ADDR : IDLE;
        nbits    <= '0;
        sda_pull <= 1'b0;
        match    <= 1'b0;
        rw       <= 1'b0;
        gcall    <= 1'b0;
        ten_hdr  <= 1'b0;
      end else begin
        case (st)
          ADDR:
            if (rise && nbits != 4'd8) begin
              sh    <= {sh[6:0], sda};
              nbits <= nbits + 1'b1;
            end else if (fall && nbits == 4'd8) begin
              if (take) begin
                st          <= ACK;
                sda_pull    <= 1'b1;
                match       <= 1'b1;
                match_pulse <= 1'b1;
                rw          <= sh[0];
                gcall       <= gc_hit;
                ten_hdr     <= (addr[6:2] == 5'b11110);
              end else begin
                st <= SKIP;
              end
            end
          ACK:
            if (fall) begin
              sda_pull <= 1'b0;
              st       <= SKIP;
            end
          default: ;
        endcase
      end
    end

  // R3
  pull_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> match);

  // R11
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);

  // R5
  gcall_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gcall |-> (match && !rw));

  // R2
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!match && !sda_pull));

  // R9
  ten_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ten_hdr |-> match);

  // R10
  rw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && $past(match)) |-> $stable(rw));
endmodule

// File: tb/i2c_addr_match_tb.sv
`timescale 1ns/1ps
module i2c_addr_match_tb_top;
  localparam int HP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [6:0] own_addr = 7'h2A, alt_addr = 7'h00;
  logic alt_mask = 1'b1, gc_en = 1'b0, promisc = 1'b0;
  logic sda_pull, match, rw, gcall, ten_hdr, match_pulse;
  logic sda_line;
  int checks = 0, fails = 0, pulses = 0;

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  i2c_addr_match dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .own_addr(own_addr), .alt_addr(alt_addr), .alt_mask(alt_mask),
    .gc_en(gc_en), .promisc(promisc), .sda_pull(sda_pull), .match(match),
    .rw(rw), .gcall(gcall), .ten_hdr(ten_hdr), .match_pulse(match_pulse)
  );

  always @(negedge clk) if (match_pulse) pulses++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start;
    m_sda = 1'b1; m_scl = 1'b1; w(HP);
    m_sda = 1'b0; w(HP);
    m_scl = 1'b0; w(HP);
  endtask

  task automatic b_rstart;
    m_sda = 1'b1; w(HP);
    m_scl = 1'b1; w(HP);
    m_sda = 1'b0; w(HP);
    m_scl = 1'b0; w(HP);
  endtask

  task automatic b_stop;
    m_sda = 1'b0; w(HP);
    m_scl = 1'b1; w(HP);
    m_sda = 1'b1; w(HP);
  endtask

  task automatic b_byte(input logic [7:0] v, output logic acked, output logic rel);
    for (int i = 7; i >= 0; i--) begin
      m_sda = v[i]; w(HP);
      m_scl = 1'b1; w(HP);
      m_scl = 1'b0; w(HP);
    end
    m_sda = 1'b1; w(HP);
    m_scl = 1'b1; w(HP/2);
    acked = ~sda_line;
    w(HP/2);
    m_scl = 1'b0; w(HP);
    rel = sda_line;
  endtask

  task automatic addr_try(input logic [7:0] v, input string req, input logic exp_ack);
    logic a, r;
    b_start;
    b_byte(v, a, r);
    check(req, a, exp_ack);
    check(req, match, exp_ack);
    b_stop;
  endtask

  task automatic t_reset;
    check("R12 sda_pull", sda_pull, 0);
    check("R12 match", match, 0);
    check("R12 rw", rw, 0);
    check("R12 gcall", gcall, 0);
    check("R12 ten_hdr", ten_hdr, 0);
    check("R12 match_pulse", match_pulse, 0);
  endtask

  task automatic t_primary;
    logic a, r;
    int p0;
    own_addr = 7'h2A; alt_addr = 7'h00; alt_mask = 1'b1;
    p0 = pulses;
    b_start;
    b_byte({7'h2A, 1'b1}, a, r);
    check("R3 ack", a, 1);
    check("R3 release", r, 1);
    check("R3 match", match, 1);
    check("R10 rw", rw, 1);
    check("R11 pulses", pulses - p0, 1);
    check("R5 gcall off", gcall, 0);
    w(5*HP);
    check("R10 match held", match, 1);
    check("R10 rw held", rw, 1);
    b_stop;
    w(HP);
    check("R2 stop clears match", match, 0);
    check("R2 stop clears rw", rw, 0);
  endtask

  task automatic t_nomatch;
    logic a, r;
    int p0;
    p0 = pulses;
    b_start;
    b_byte({7'h2B, 1'b0}, a, r);
    check("R4 no ack", a, 0);
    check("R4 no match", match, 0);
    b_byte({7'h2A, 1'b0}, a, r);
    check("R4 ignored byte", a, 0);
    check("R4 ignored match", match, 0);
    check("R4 no pulse", pulses - p0, 0);
    b_stop;
  endtask

  task automatic t_rstart;
    logic a, r;
    b_start;
    b_byte({7'h2A, 1'b1}, a, r);
    check("R2 first ack", a, 1);
    b_rstart;
    check("R2 rstart clears", match, 0);
    b_byte({7'h2A, 1'b0}, a, r);
    check("R2 rstart ack", a, 1);
    check("R2 rstart rw", rw, 0);
    b_byte({7'h2B, 1'b0}, a, r);
    b_rstart;
    b_byte({7'h2B, 1'b0}, a, r);
    check("R2 rstart new miss", a, 0);
    b_stop;
  endtask

  task automatic t_gcall;
    gc_en = 1'b1;
    addr_try(8'h00, "R5 gc write", 1);
    b_start;
    begin
      logic a, r;
      b_byte(8'h00, a, r);
      check("R5 gcall flag", gcall, 1);
      b_stop;
      b_start;
      b_byte(8'h01, a, r);
      check("R5 gc read nack", a, 0);
      check("R5 gc read flag", gcall, 0);
      b_stop;
    end
    gc_en = 1'b0;
    addr_try(8'h00, "R5 gc disabled", 0);
  endtask

  task automatic t_mask;
    own_addr = 7'h50; alt_addr = 7'h03; alt_mask = 1'b1;
    addr_try({7'h53, 1'b0}, "R6 mask 53", 1);
    addr_try({7'h52, 1'b1}, "R6 mask 52", 1);
    addr_try({7'h54, 1'b0}, "R6 mask 54", 0);
  endtask

  task automatic t_second;
    own_addr = 7'h50; alt_addr = 7'h11; alt_mask = 1'b0;
    addr_try({7'h11, 1'b0}, "R7 second", 1);
    addr_try({7'h50, 1'b0}, "R7 primary", 1);
    addr_try({7'h12, 1'b0}, "R7 miss", 0);
  endtask

  task automatic t_promisc;
    promisc = 1'b1;
    addr_try({7'h7F, 1'b1}, "R8 promisc 7F", 1);
    addr_try({7'h01, 1'b0}, "R8 promisc 01", 1);
    promisc = 1'b0;
    addr_try({7'h01, 1'b0}, "R8 promisc off", 0);
  endtask

  task automatic t_ten;
    logic a, r;
    own_addr = 7'b1111010; alt_addr = 7'h00; alt_mask = 1'b1;
    b_start;
    b_byte({7'b1111010, 1'b0}, a, r);
    check("R9 header ack", a, 1);
    check("R9 ten_hdr", ten_hdr, 1);
    b_stop;
    own_addr = 7'h2A;
    b_start;
    b_byte({7'h2A, 1'b0}, a, r);
    check("R9 plain ack", a, 1);
    check("R9 ten_hdr clear", ten_hdr, 0);
    b_stop;
  endtask

  task automatic t_glitch;
    logic a, r;
    own_addr = 7'h2A; alt_mask = 1'b1; alt_addr = 7'h00;
    b_start;
    b_byte({7'h2A, 1'b1}, a, r);
    m_scl = 1'b1; w(HP);
    m_sda = 1'b0; w(1);
    m_sda = 1'b1; w(HP);
    check("R1 short low kept", match, 1);
    m_sda = 1'b0; w(2);
    m_sda = 1'b1; w(HP);
    check("R1 two-clock low taken", match, 0);
    m_scl = 1'b0; w(HP);
    b_start;
    b_byte({7'h2A, 1'b0}, a, r);
    m_scl = 1'b1; w(HP);
    m_scl = 1'b0; w(1);
    m_scl = 1'b1; w(HP);
    m_sda = 1'b0; w(HP);
    check("R1 scl glitch not an edge", match, 0);
    m_sda = 1'b1; w(HP);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    w(3);
    rst_n = 1'b1;
    w(HP);
    t_reset;
    t_primary;
    t_nomatch;
    t_rstart;
    t_gcall;
    t_mask;
    t_second;
    t_promisc;
    t_ten;
    t_glitch;
    w(HP);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule